// File: doc/BRIEF.md
# Multi-Context Load-Reserve Monitor

This block keeps the load-locked / store-conditional reservations for a set of hardware thread contexts that share one memory. Each cycle it may accept one request. The request carries a context index, an operation, a physical address and an uncacheable flag. For each context the block holds a reservation address, a valid flag and a running count of consecutive conditional-store failures. It tells the memory side whether the request commits a write. For conditional stores it also returns a result code.

Reservations are compared at 16-byte granule size: the low 4 address bits are ignored. Any store that commits, from any context, removes every reservation on the same granule. A context that keeps failing its conditional stores raises a one-cycle warning each time its failure run reaches another multiple of a threshold. The warning carries the context index and can be used to flag a livelock.

Top module: `resv_monitor`

## Requirements
- R1: A locked load (op 2'b01) sets the issuing context's reservation flag and records the request address as that context's reservation address.
- R2: A cacheable conditional store (op 2'b10, uncached low) commits, with mem_we high one cycle later, only if the issuer's flag is set and its reservation address equals the store address with bits [3:0] ignored.
- R3: For a cacheable conditional store, rsp_valid is high one cycle after the request and rsp_code equals the issuer's reservation flag at request time (1 or 0), even when the address does not match. rsp_valid is low after every other operation.
- R4: A conditional store that does not commit leaves mem_we low, clears only the issuer's reservation flag, and increments the issuer's failure count.
- R5: An uncacheable conditional store returns rsp_code 2, commits a write, resets the issuer's failure count, and clears matching reservations like any committed store.
- R6: Each committed store clears the reservation flag of every context, the issuer included, whose reservation address matches the store address on bits above [3:0].
- R7: When a context's consecutive failure count reaches a nonzero multiple of WARN_EVERY (default 100000), warn_valid is high for one cycle, in the same cycle as that store's response, with warn_ctx set to that context. A committing conditional store resets the count to zero.
- R8: An ordinary load (op 2'b00) produces no response and no write, and leaves every reservation unchanged.
- R9: Reset clears all reservation flags, failure counts and outputs.
- R10: An ordinary store (op 2'b11) raises mem_we one cycle later and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ctx | input | CTXW | Issuing context index |
| req_op | input | 2 | 00 load, 01 locked load, 10 conditional store, 11 store |
| req_addr | input | AW | Physical address |
| req_uncached | input | 1 | Address is uncacheable |
| rsp_valid | output | 1 | Conditional-store result present |
| rsp_code | output | 2 | 0 fail, 1 success flag, 2 uncacheable |
| mem_we | output | 1 | Write toward memory commits |
| warn_valid | output | 1 | Failure-run threshold crossed |
| warn_ctx | output | CTXW | Context that crossed the threshold |

## Verification
The bench goes after the granule edge: an offset of 0xF inside a reserved line must still commit, and 0x10 must not. A design that compared full addresses would fail the first case, and one that masked too many bits would wrongly pass the second. It drives the case where the flag is set but the address differs, which must return code 1 with no write. It checks cross-context clearing by plain stores, by successful conditional stores and by uncacheable conditional stores. A missing clear here lets a stale reservation commit later. With a small threshold it counts the warnings from a long failure run, so an off-by-one counter shows up as a shifted or missing pulse.

// File: rtl/resv_monitor.sv
module resv_monitor #(
  parameter int NCTX       = 4,
  parameter int AW         = 32,
  parameter int GRAN       = 4,
  parameter int WARN_EVERY = 100000,
  localparam int CTXW      = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [CTXW-1:0] req_ctx,
  input  logic [1:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_uncached,
  output logic            rsp_valid,
  output logic [1:0]      rsp_code,
  output logic            mem_we,
  output logic            warn_valid,
  output logic [CTXW-1:0] warn_ctx
);
  localparam int TW  = AW - GRAN;
  localparam int FCW = $clog2(WARN_EVERY + 1);
  localparam logic [FCW-1:0] WRAP = FCW'(WARN_EVERY - 1);

  logic [NCTX-1:0] resv_vld;
  logic [TW-1:0]   resv_tag [NCTX];
  logic [FCW-1:0]  fail_cnt [NCTX];

  wire [TW-1:0] req_tag = req_addr[AW-1:GRAN];
  wire is_ll = req_valid && req_op == 2'b01;
  wire is_sc = req_valid && req_op == 2'b10;
  wire is_st = req_valid && req_op == 2'b11;

  wire own_vld   = resv_vld[req_ctx];
  wire own_match = resv_tag[req_ctx] == req_tag;
  wire sc_unc    = is_sc && req_uncached;
  wire sc_ok     = is_sc && !req_uncached && own_vld && own_match;
  wire sc_fail   = is_sc && !req_uncached && !(own_vld && own_match);
  wire commit    = is_st || sc_ok || sc_unc;
  wire cnt_wrap  = fail_cnt[req_ctx] == WRAP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCTX; c++) begin
        resv_vld[c] <= 1'b0;
        resv_tag[c] <= '0;
        fail_cnt[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NCTX; c++) begin
        if (is_ll && req_ctx == CTXW'(c)) begin
          resv_vld[c] <= 1'b1;
          resv_tag[c] <= req_tag;
        end else if (commit && resv_tag[c] == req_tag) begin
          resv_vld[c] <= 1'b0;
        end else if (sc_fail && req_ctx == CTXW'(c)) begin
          resv_vld[c] <= 1'b0;
        end

        if (sc_fail && req_ctx == CTXW'(c))
          fail_cnt[c] <= cnt_wrap ? '0 : fail_cnt[c] + 1'b1;
        else if ((sc_ok || sc_unc) && req_ctx == CTXW'(c))
          fail_cnt[c] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_code   <= 2'd0;
      mem_we     <= 1'b0;
      warn_valid <= 1'b0;
      warn_ctx   <= '0;
    end else begin
      rsp_valid  <= is_sc;
      rsp_code   <= sc_unc ? 2'd2 : {1'b0, own_vld};
      mem_we     <= commit;
      warn_valid <= sc_fail && cnt_wrap;
      warn_ctx   <= req_ctx;
    end
  end
endmodule

module resv_monitor_chk #(
  parameter int NCTX = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      req_op,
  input logic            rsp_valid,
  input logic [1:0]      rsp_code,
  input logic            mem_we,
  input logic            warn_valid,
  input logic [NCTX-1:0] resv_vld
);
  a_r3_rsp_only_sc: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_op == 2'b10));
  a_r3_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_code != 2'd3);
  a_r4_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'd0) |-> !mem_we);
  a_r5_unc_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'd2) |-> mem_we);
  a_r7_warn_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    warn_valid |-> (rsp_valid && !mem_we));
  a_r8_load_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b00) |=> ($stable(resv_vld) && !rsp_valid && !mem_we));
endmodule

bind resv_monitor resv_monitor_chk #(.NCTX(NCTX)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code), .mem_we(mem_we),
  .warn_valid(warn_valid), .resv_vld(resv_vld)
);

// File: tb/resv_monitor_test.sv
module resv_monitor_test;
  localparam int NCTX = 4;
  localparam int AW   = 32;
  localparam int WARN = 7;
  localparam int CTXW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [CTXW-1:0] req_ctx = '0;
  logic [1:0] req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic req_uncached = 1'b0;
  logic rsp_valid, mem_we, warn_valid;
  logic [1:0] rsp_code;
  logic [CTXW-1:0] warn_ctx;

  always #10 clk = ~clk;

  resv_monitor #(.NCTX(NCTX), .AW(AW), .GRAN(4), .WARN_EVERY(WARN)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctx(req_ctx),
    .req_op(req_op), .req_addr(req_addr), .req_uncached(req_uncached),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .mem_we(mem_we),
    .warn_valid(warn_valid), .warn_ctx(warn_ctx)
  );

  int tests = 0, fails = 0, warns = 0;
  bit m_vld [NCTX];
  logic [AW-1:0] m_addr [NCTX];
  int m_cnt [NCTX];

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic bit same_line(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a[AW-1:4] == b[AW-1:4];
  endfunction

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic issue(input int c, input logic [1:0] op, input logic [AW-1:0] a, input bit unc);
    bit e_rsp, e_we, e_warn, ok, fl;
    int e_code;
    string tag;
    req_valid = 1'b1; req_ctx = CTXW'(c); req_op = op; req_addr = a; req_uncached = unc;
    e_rsp = (op == 2'b10);
    e_code = unc ? 2 : int'(m_vld[c]);
    ok = e_rsp && !unc && m_vld[c] && same_line(m_addr[c], a);
    fl = e_rsp && !unc && !ok;
    e_we = (op == 2'b11) || (e_rsp && (unc || ok));
    e_warn = fl && ((m_cnt[c] + 1) % WARN == 0);
    tag = op == 2'b00 ? "R8" : op == 2'b01 ? "R1" : op == 2'b11 ? "R10/R6" :
          unc ? "R5" : ok ? "R2" : "R4";
    if (op == 2'b01) begin m_vld[c] = 1'b1; m_addr[c] = a; end
    if (e_we)
      for (int j = 0; j < NCTX; j++) if (m_vld[j] && same_line(m_addr[j], a)) m_vld[j] = 1'b0;
    if (fl) begin m_vld[c] = 1'b0; m_cnt[c]++; end
    if (ok || (e_rsp && unc)) m_cnt[c] = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == e_rsp, {tag, " R3 rsp_valid"}, rsp_valid, e_rsp);
    if (e_rsp) chk(rsp_code == e_code, {tag, " R3 rsp_code"}, rsp_code, e_code);
    chk(mem_we == e_we, {tag, " mem_we"}, mem_we, e_we);
    chk(warn_valid == e_warn, "R7 warn_valid", warn_valid, e_warn);
    if (e_warn) begin
      warns++;
      chk(warn_ctx == CTXW'(c), "R7 warn_ctx", warn_ctx, c);
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_up();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int j = 0; j < NCTX; j++) begin m_vld[j] = 0; m_addr[j] = '0; m_cnt[j] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(!rsp_valid && !mem_we && !warn_valid, "R9 outputs after reset", rsp_valid, 0);
    for (int j = 0; j < NCTX; j++) issue(j, 2'b10, 32'h40, 0);      // R9 no flag set after reset

    issue(0, 2'b01, 32'h100, 0); issue(0, 2'b10, 32'h10F, 0);       // R1 R2 granule edge inside
    issue(0, 2'b10, 32'h100, 0);                                    // R6 own commit cleared flag
    issue(1, 2'b01, 32'h200, 0); issue(1, 2'b10, 32'h210, 0);       // R3 flag set, line differs
    issue(0, 2'b01, 32'h300, 0); issue(1, 2'b01, 32'h308, 0);
    issue(2, 2'b11, 32'h30F, 0);                                    // R10 R6 plain store clears both
    issue(0, 2'b10, 32'h300, 0); issue(1, 2'b10, 32'h300, 0);
    issue(3, 2'b01, 32'h400, 0); issue(2, 2'b00, 32'h400, 0);       // R8 load leaves reservation
    issue(3, 2'b10, 32'h400, 0);
    issue(2, 2'b10, 32'h500, 1);                                    // R5 uncached code 2
    issue(0, 2'b01, 32'h600, 0); issue(1, 2'b01, 32'h600, 0);
    issue(1, 2'b10, 32'h604, 1); issue(0, 2'b10, 32'h600, 0);       // R5 uncached store clears
    issue(2, 2'b01, 32'h800, 0); issue(3, 2'b10, 32'h800, 0);       // R4 other context unaffected
    issue(2, 2'b10, 32'h800, 0);

    warns = 0;
    for (int k = 0; k < 2 * WARN; k++) issue(1, 2'b10, 32'h900, 0); // R7 two crossings
    chk(warns == 2, "R7 warning count", warns, 2);
    issue(1, 2'b10, 32'h900, 1);                                    // R5 count reset
    warns = 0;
    for (int k = 0; k < WARN - 1; k++) issue(1, 2'b10, 32'h900, 0);
    chk(warns == 0, "R5 R7 count restarted", warns, 0);

    for (int k = 0; k < 4000; k++) begin
      int c = $urandom % NCTX;
      logic [1:0] op = 2'($urandom % 4);
      logic [AW-1:0] a = 32'h1000 + 32'(($urandom % 4) * 16) + 32'($urandom % 16);
      bit unc = ($urandom % 8) == 0;
      issue(c, op, a, unc);
    end
    finish_up();
  end
endmodule